// File: doc/BRIEF.md
# Shared-SRAM Multi-Queue FIFO Manager

This block keeps a set of independent 32-bit word queues that all store their data in one shared single-port SRAM inside the block. Every queue is placed and sized by one packed configuration word: a base given in 16-word pages, a length code, and two 3-bit watermark codes. For each queue the block holds a read offset, a write offset, an occupancy count and a sticky overflow bit. From these it derives four status flags.

A bus master writes a queue's access address to append a word and reads it to remove the oldest word. Packed status words give the flags of the lower half of the queues. Two separate 32-bit words give the nearly-empty and full flags of the upper half. Every bus transaction is accepted in the cycle in which `bus_sel` is high. It is answered one cycle later with `bus_ready` and, for reads, `bus_rdata`. A configuration word of zero marks a queue as unused. Allocation of pages and interrupt generation belong to the surrounding system.

Top module: `shared_fifo_mgr`

## Requirements
- R1: After reset every lower-half status nibble reads 0x3, both overflow words read 0, the upper nearly-empty word reads 0xFFFFFFFF, the upper full word reads 0, and every configuration word reads 0.
- R2: The configuration word has these fields:
  - nearly-full code at bits 31:29
  - nearly-empty code at bits 28:26
  - length code at bits 25:24, where 0/1/2/3 mean 16/32/64/128 words
  - base page at bits 21:14

  The word reads back as it was written. Writing it empties the queue and clears its overflow bit.
- R3: Words are popped in the order they were pushed. `bus_ready` is high exactly in the cycle after a cycle with `bus_sel` high. Word addresses, for 64 queues: access at 0x00+q, configuration at 0x40+q, status region at 0x80+k.
- R4: Queues placed on disjoint pages keep their contents apart when pushes and pops to them interleave.
- R5: A pop from an empty queue returns 0 and leaves the queue unchanged.
- R6: The full flag is set when the count equals the length. A push to a full queue is dropped and sets the sticky overflow bit of queue q. For q below half, that bit is bit 2*(q mod 16) of overflow word q/16 at status offset 8+q/16.
- R7: A write to an overflow word clears each queue's bit whose written bit is 0. Bits written as 1 leave the flag unchanged.
- R8: Nearly-empty holds when the count is at or below the threshold of its code. Code 0 gives a threshold of 0, and code n>0 gives 2^(n-1). For queue q below half it is bit 1 of the nibble at bits 4*(q mod 8) of status word q/8 (offset q/8). Bit 0 is empty, bit 2 nearly-full and bit 3 full.
- R9: Nearly-full holds when the free space (length minus count) is at or below the threshold of its code.
- R10: For an upper-half queue q, bit q-half of the word at offset 12 is its nearly-empty flag. The same bit of the word at offset 13 is its full flag.
- R11: A push to a queue whose configuration word is zero is dropped. It does not set overflow, and the queue keeps reading 0x3 status.
- R12: The read and write offsets wrap modulo the queue length. The data stays correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Transaction request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | QW+2 (8) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Response strobe, one cycle after bus_sel |

## Verification
The queue function is tried with four patterns:
- A short in-order burst, which separates correct ordering from swapped offsets.
- Pushes and pops interleaved across three queues, which exposes page or offset cross-talk.
- Filling past the length, which tells a dropped word from an overwritten one and shows whether overflow is sticky.
- Two fill-and-drain rounds that cross the wrap point, which tells a modulo offset from an unbounded one.

Watermark codes 0, 1, 2 and 3 are stepped through their exact thresholds, one entry either side. This separates the at-or-below comparison from a strict one.

// File: rtl/qm_pkg.sv
package qm_pkg;

   localparam int CNT_W = 8;      // occupancy 0..128
   localparam int PTR_W = 7;      // offset inside a queue, 0..127
   localparam int PAGE_WORDS = 16;

   typedef struct packed {
      logic [2:0]  nf_code;   // 31:29
      logic [2:0]  ne_code;   // 28:26
      logic [1:0]  len_code;  // 25:24
      logic [1:0]  spare;     // 23:22
      logic [7:0]  base;      // 21:14
      logic [13:0] low;       // 13:0
   } qcfg_t;

   typedef struct packed {
      logic full;
      logic nfull;
      logic nempty;
      logic empty;
   } qflags_t;

   function automatic logic [CNT_W-1:0] len_of(input logic [1:0] code);
      return CNT_W'(PAGE_WORDS) << code;
   endfunction

   function automatic logic [CNT_W-1:0] wm_thr(input logic [2:0] code);
      return (code == 3'd0) ? '0 : (CNT_W'(1) << (code - 3'd1));
   endfunction

endpackage

// File: rtl/qm_sram.sv
module qm_sram #(
   parameter int DEPTH = 1024,
   parameter int WIDTH = 32,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             en,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end

endmodule

// File: rtl/qm_flag_gen.sv
module qm_flag_gen
   import qm_pkg::*;
(
   input  logic [1:0]       len_code,
   input  logic [2:0]       ne_code,
   input  logic [2:0]       nf_code,
   input  logic [CNT_W-1:0] cnt,
   output qflags_t          flags
);

   logic [CNT_W-1:0] qlen;
   logic [CNT_W-1:0] space;

   assign qlen  = len_of(len_code);
   assign space = qlen - cnt;

   always_comb begin
      flags.empty  = (cnt == '0);
      flags.full   = (cnt == qlen);
      flags.nempty = (cnt <= wm_thr(ne_code));
      flags.nfull  = (space <= wm_thr(nf_code));
   end

endmodule

// File: rtl/qm_queue_ctx.sv
module qm_queue_ctx
   import qm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   input  logic             push,
   input  logic             pop,
   input  logic             ovf_clr,
   output qcfg_t            cfg,
   output logic [CNT_W-1:0] cnt,
   output logic [PTR_W-1:0] rd_off,
   output logic [PTR_W-1:0] wr_off,
   output qflags_t          flags,
   output logic             ovf,
   output logic             push_ok,
   output logic             pop_ok
);

   logic             in_use;
   logic             push_drop;
   logic [PTR_W-1:0] wrap_mask;

   assign in_use    = (cfg != '0);
   assign wrap_mask = PTR_W'(len_of(cfg.len_code) - CNT_W'(1));
   assign push_ok   = push & in_use & ~flags.full;
   assign push_drop = push & in_use & flags.full;
   assign pop_ok    = pop & ~flags.empty;

   qm_flag_gen u_flags (
      .len_code (cfg.len_code),
      .ne_code  (cfg.ne_code),
      .nf_code  (cfg.nf_code),
      .cnt      (cnt),
      .flags    (flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg    <= '0;
         cnt    <= '0;
         rd_off <= '0;
         wr_off <= '0;
         ovf    <= 1'b0;
      end else if (cfg_we) begin
         cfg    <= qcfg_t'(cfg_wdata);
         cnt    <= '0;
         rd_off <= '0;
         wr_off <= '0;
         ovf    <= 1'b0;
      end else begin
         if (push_ok) wr_off <= (wr_off + PTR_W'(1)) & wrap_mask;
         if (pop_ok)  rd_off <= (rd_off + PTR_W'(1)) & wrap_mask;
         cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
         if (push_drop)    ovf <= 1'b1;
         else if (ovf_clr) ovf <= 1'b0;
      end
   end

endmodule

// File: rtl/shared_fifo_mgr.sv
module shared_fifo_mgr
   import qm_pkg::*;
#(
   parameter int NUM_QUEUES = 64,
   parameter int NUM_PAGES  = 64,
   localparam int QW     = $clog2(NUM_QUEUES),
   localparam int ADDR_W = QW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_ready
);

   localparam int HALF        = NUM_QUEUES / 2;
   localparam int SRAM_DEPTH  = NUM_PAGES * PAGE_WORDS;
   localparam int SA_W        = $clog2(SRAM_DEPTH);
   localparam int OVF_BASE    = 8;
   localparam int UP_NE_OFS   = 12;
   localparam int UP_FULL_OFS = 13;

   if (NUM_QUEUES != 32 && NUM_QUEUES != 64) begin : g_bad_nq
      $error("NUM_QUEUES must be 32 or 64");
   end
   if (NUM_PAGES < 16 || NUM_PAGES > 256 || (1 << $clog2(NUM_PAGES)) != NUM_PAGES) begin : g_bad_np
      $error("NUM_PAGES must be a power of two in 16..256");
   end

   // ---------------- decode ----------------
   logic [1:0]    region;
   logic [QW-1:0] idx;
   logic          acc_hit, cfg_hit, stat_hit, ovf_wr;

   assign region   = bus_addr[ADDR_W-1 -: 2];
   assign idx      = bus_addr[QW-1:0];
   assign acc_hit  = bus_sel && (region == 2'd0);
   assign cfg_hit  = bus_sel && (region == 2'd1);
   assign stat_hit = bus_sel && (region == 2'd2);
   assign ovf_wr   = stat_hit && bus_wr && (idx >= QW'(OVF_BASE)) && (idx < QW'(OVF_BASE + 4));

   // ---------------- per-queue state ----------------
   qcfg_t            q_cfg    [NUM_QUEUES];
   logic [CNT_W-1:0] q_cnt    [NUM_QUEUES];
   logic [PTR_W-1:0] q_rd_off [NUM_QUEUES];
   logic [PTR_W-1:0] q_wr_off [NUM_QUEUES];
   qflags_t          q_flags  [NUM_QUEUES];

   logic [NUM_QUEUES-1:0]       q_ovf, q_ovf_clr, q_full, q_empty, q_push_ok, q_pop_ok;
   logic [NUM_QUEUES*CNT_W-1:0] q_cnt_flat;

   logic [8*32-1:0] stat_lo_flat;
   logic [4*32-1:0] ovf_flat;
   logic [31:0]     up_ne, up_full;

   for (genvar i = 0; i < NUM_QUEUES; i++) begin : g_q
      logic hit;
      assign hit = (idx == QW'(i));

      if (i < HALF) begin : g_lo
         localparam int OW = i / 16;
         localparam int OB = 2 * (i % 16);
         assign q_ovf_clr[i] = ovf_wr && (idx[1:0] == 2'(OW)) && !bus_wdata[OB];
         assign stat_lo_flat[4*i +: 4] = q_flags[i];
         assign ovf_flat[2*i]          = q_ovf[i];
         assign ovf_flat[2*i+1]        = 1'b0;
      end else begin : g_hi
         assign q_ovf_clr[i]     = 1'b0;
         assign up_ne[i-HALF]    = q_flags[i].nempty;
         assign up_full[i-HALF]  = q_flags[i].full;
      end

      qm_queue_ctx u_ctx (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_we    (cfg_hit && bus_wr && hit),
         .cfg_wdata (bus_wdata),
         .push      (acc_hit && bus_wr && hit),
         .pop       (acc_hit && !bus_wr && hit),
         .ovf_clr   (q_ovf_clr[i]),
         .cfg       (q_cfg[i]),
         .cnt       (q_cnt[i]),
         .rd_off    (q_rd_off[i]),
         .wr_off    (q_wr_off[i]),
         .flags     (q_flags[i]),
         .ovf       (q_ovf[i]),
         .push_ok   (q_push_ok[i]),
         .pop_ok    (q_pop_ok[i])
      );

      assign q_full[i]  = q_flags[i].full;
      assign q_empty[i] = q_flags[i].empty;
      assign q_cnt_flat[i*CNT_W +: CNT_W] = q_cnt[i];
   end

   assign stat_lo_flat[8*32-1:4*HALF] = '0;
   assign ovf_flat[4*32-1:2*HALF]     = '0;
   if (HALF < 32) begin : g_pad_up
      assign up_ne[31:HALF]   = '0;
      assign up_full[31:HALF] = '0;
   end

   // ---------------- register read mux ----------------
   logic [31:0] reg_rd;

   always_comb begin
      reg_rd = '0;
      case (region)
         2'd1: reg_rd = q_cfg[idx];
         2'd2: begin
            if (idx < QW'(OVF_BASE))
               reg_rd = stat_lo_flat[32*idx[2:0] +: 32];
            else if (idx < QW'(OVF_BASE + 4))
               reg_rd = ovf_flat[32*idx[1:0] +: 32];
            else if (idx == QW'(UP_NE_OFS))
               reg_rd = up_ne;
            else if (idx == QW'(UP_FULL_OFS))
               reg_rd = up_full;
         end
         default: reg_rd = '0;
      endcase
   end

   // ---------------- shared SRAM ----------------
   qcfg_t            sel_cfg;
   logic [PTR_W-1:0] sel_off;
   logic [SA_W-1:0]  word_addr;
   logic             sram_en;
   logic [31:0]      sram_q;

   assign sel_cfg   = q_cfg[idx];
   assign sel_off   = bus_wr ? q_wr_off[idx] : q_rd_off[idx];
   assign word_addr = SA_W'({sel_cfg.base, 4'b0000}) + SA_W'(sel_off);
   assign sram_en   = |(q_push_ok | q_pop_ok);

   qm_sram #(.DEPTH(SRAM_DEPTH), .WIDTH(32)) u_sram (
      .clk   (clk),
      .en    (sram_en),
      .we    (bus_wr),
      .addr  (word_addr),
      .wdata (bus_wdata),
      .rdata (sram_q)
   );

   // ---------------- response stage ----------------
   logic        rsp_ready, rsp_sram;
   logic [31:0] rsp_reg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_ready <= 1'b0;
         rsp_sram  <= 1'b0;
         rsp_reg   <= '0;
      end else begin
         rsp_ready <= bus_sel;
         rsp_sram  <= acc_hit && !bus_wr && (|q_pop_ok);
         rsp_reg   <= (bus_sel && !bus_wr) ? reg_rd : '0;
      end
   end

   assign bus_ready = rsp_ready;
   assign bus_rdata = rsp_sram ? sram_q : rsp_reg;

endmodule

// File: rtl/qm_fifo_mgr_chk.sv
module qm_fifo_mgr_chk #(
   parameter int NUM_QUEUES = 64,
   parameter int CNT_W      = 8,
   localparam int QW     = $clog2(NUM_QUEUES),
   localparam int ADDR_W = QW + 2
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_sel,
   input logic                        bus_wr,
   input logic [ADDR_W-1:0]           bus_addr,
   input logic [31:0]                 bus_rdata,
   input logic                        bus_ready,
   input logic [NUM_QUEUES*CNT_W-1:0] q_cnt_flat,
   input logic [NUM_QUEUES-1:0]       q_full,
   input logic [NUM_QUEUES-1:0]       q_empty,
   input logic [NUM_QUEUES-1:0]       q_ovf
);

   logic [NUM_QUEUES*CNT_W-1:0] prev_cnt;
   logic [NUM_QUEUES-1:0]       cnt_chg;
   logic                        pop_of_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_cnt <= '0;
      else        prev_cnt <= q_cnt_flat;
   end

   for (genvar i = 0; i < NUM_QUEUES; i++) begin : g_chg
      assign cnt_chg[i] = (q_cnt_flat[i*CNT_W +: CNT_W] != prev_cnt[i*CNT_W +: CNT_W]);
   end

   assign pop_of_empty = bus_sel && !bus_wr && (bus_addr[ADDR_W-1 -: 2] == 2'd0)
                         && q_empty[bus_addr[QW-1:0]];

   // R3
   ready_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel |=> bus_ready);

   // R3
   no_spurious_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> !bus_ready);

   // R5
   empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_of_empty |=> (bus_rdata == 32'd0));

   // R6
   full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full & q_empty) == '0);

   // R6
   ovf_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(q_ovf & ~$past(q_ovf))) |-> $past(bus_sel && bus_wr));

   // R4
   one_queue_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cnt_chg) <= 1);

endmodule

bind shared_fifo_mgr qm_fifo_mgr_chk #(
   .NUM_QUEUES (NUM_QUEUES),
   .CNT_W      (qm_pkg::CNT_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .bus_ready  (bus_ready),
   .q_cnt_flat (q_cnt_flat),
   .q_full     (q_full),
   .q_empty    (q_empty),
   .q_ovf      (q_ovf)
);

// File: tb/test_shared_fifo_mgr.sv
`timescale 1ns/1ps
module test_shared_fifo_mgr;

   localparam int AW  = 8;
   localparam logic [AW-1:0] CFG = 8'h40;
   localparam logic [AW-1:0] ST  = 8'h80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0, wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          ready;

   int n_checks = 0;
   int n_errors = 0;

   always #2.5 clk = ~clk;

   shared_fifo_mgr i_shared_fifo_mgr (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d, output logic rdy);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk);
      d = rdata; rdy = ready;
      sel = 1'b0;
   endtask

   function automatic logic [31:0] cfg_word(input int base, input int len_code, input int ne, input int nf);
      return (32'(nf) << 29) | (32'(ne) << 26) | (32'(len_code) << 24) | (32'(base) << 14);
   endfunction

   function automatic logic [31:0] nib(input logic [31:0] w, input int q);
      return (w >> (4 * (q % 8))) & 32'hF;
   endfunction

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      logic r;
      bus_read(a, d, r);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      for (int k = 0; k < 4; k++) begin
         rd(ST + AW'(k), d); check("R1 status word", d, 32'h33333333);
      end
      rd(ST + 8, d);  check("R1 overflow word0", d, 32'h0);
      rd(ST + 9, d);  check("R1 overflow word1", d, 32'h0);
      rd(ST + 12, d); check("R1 upper nearly-empty", d, 32'hFFFFFFFF);
      rd(ST + 13, d); check("R1 upper full", d, 32'h0);
      rd(CFG + 5, d); check("R1 config zero", d, 32'h0);
   endtask

   task automatic t_order;
      logic [31:0] d;
      logic r;
      bus_write(CFG + 0, cfg_word(4, 0, 0, 0));
      rd(CFG + 0, d); check("R2 config readback", d, cfg_word(4, 0, 0, 0));
      for (int k = 0; k < 5; k++) bus_write(AW'(0), 32'hA000 + 32'(k));
      for (int k = 0; k < 5; k++) begin
         bus_read(AW'(0), d, r);
         check("R3 pop order", d, 32'hA000 + 32'(k));
         if (k == 0) check("R3 ready after sel", 32'(r), 32'd1);
      end
      @(negedge clk);
      check("R3 ready drops", 32'(ready), 32'd0);
   endtask

   task automatic t_independent;
      logic [31:0] d;
      bus_write(CFG + 1, cfg_word(5, 1, 0, 0));
      bus_write(CFG + 2, cfg_word(7, 0, 0, 0));
      bus_write(AW'(1), 32'h1111);
      bus_write(AW'(2), 32'h2222);
      bus_write(AW'(1), 32'h1112);
      rd(AW'(2), d); check("R4 queue2 word", d, 32'h2222);
      rd(AW'(1), d); check("R4 queue1 first", d, 32'h1111);
      rd(AW'(1), d); check("R4 queue1 second", d, 32'h1112);
   endtask

   task automatic t_empty_pop;
      logic [31:0] d;
      rd(AW'(0), d);  check("R5 empty pop returns 0", d, 32'h0);
      rd(ST + 0, d);  check("R5 still empty status", nib(d, 0), 32'h3);
      bus_write(AW'(0), 32'h55);
      rd(AW'(0), d);  check("R5 pointers unchanged", d, 32'h55);
   endtask

   task automatic t_full_ovf;
      logic [31:0] d;
      bus_write(CFG + 3, cfg_word(8, 0, 0, 0));
      for (int k = 0; k < 16; k++) bus_write(AW'(3), 32'h300 + 32'(k));
      rd(ST + 0, d); check("R6 full status q3", nib(d, 3), 32'hC);
      rd(ST + 8, d); check("R6 no overflow yet", d, 32'h0);
      bus_write(AW'(3), 32'hBAD);
      rd(ST + 8, d); check("R6 overflow bit q3", d, 32'h40);
      bus_write(ST + 8, 32'hFFFFFFFF);
      rd(ST + 8, d); check("R7 write one keeps", d, 32'h40);
      rd(AW'(3), d); check("R6 oldest kept", d, 32'h300);
      for (int k = 1; k < 16; k++) rd(AW'(3), d);
      check("R6 dropped word absent", d, 32'h30F);
      rd(ST + 0, d); check("R6 drained status q3", nib(d, 3), 32'h3);
      bus_write(ST + 8, 32'h0);
      rd(ST + 8, d); check("R7 write zero clears", d, 32'h0);
   endtask

   task automatic t_watermarks;
      logic [31:0] d;
      // code 3 -> threshold 4, code 2 -> threshold 2, length 32
      bus_write(CFG + 4, cfg_word(16, 1, 3, 2));
      for (int k = 0; k < 4; k++) bus_write(AW'(4), 32'(k));
      rd(ST + 0, d); check("R8 nearly empty at threshold", nib(d, 4), 32'h2);
      bus_write(AW'(4), 32'h4);
      rd(ST + 0, d); check("R8 above threshold", nib(d, 4), 32'h0);
      for (int k = 5; k < 29; k++) bus_write(AW'(4), 32'(k));
      rd(ST + 0, d); check("R9 free 3 not nearly full", nib(d, 4), 32'h0);
      bus_write(AW'(4), 32'd29);
      rd(ST + 0, d); check("R9 nearly full at free 2", nib(d, 4), 32'h4);
      bus_write(AW'(4), 32'd30);
      bus_write(AW'(4), 32'd31);
      rd(ST + 0, d); check("R2 length 32 full", nib(d, 4), 32'hC);
   endtask

   task automatic t_upper;
      logic [31:0] d;
      bus_write(CFG + 40, cfg_word(24, 0, 1, 0));
      bus_write(AW'(40), 32'h40);
      rd(ST + 12, d); check("R10 upper nearly empty at 1", d, 32'hFFFFFFFF);
      bus_write(AW'(40), 32'h41);
      rd(ST + 12, d); check("R10 upper nearly empty clear", d, ~(32'h1 << 8));
      rd(ST + 13, d); check("R10 upper not full", d, 32'h0);
      for (int k = 2; k < 16; k++) bus_write(AW'(40), 32'h40 + 32'(k));
      rd(ST + 13, d); check("R10 upper full bit", d, 32'h1 << 8);
   endtask

   task automatic t_unconfig;
      logic [31:0] d;
      bus_write(AW'(10), 32'hDEAD);
      rd(AW'(10), d); check("R11 unused queue pop", d, 32'h0);
      rd(ST + 8, d);  check("R11 no overflow", d, 32'h0);
      rd(ST + 1, d);  check("R11 status stays", nib(d, 10), 32'h3);
   endtask

   task automatic t_wrap;
      logic [31:0] d;
      bus_write(CFG + 6, cfg_word(32, 0, 0, 0));
      for (int round = 0; round < 2; round++) begin
         for (int k = 0; k < 10 + 2 * round; k++) bus_write(AW'(6), 32'h6000 + 32'(round * 256 + k));
         for (int k = 0; k < 10 + 2 * round; k++) begin
            rd(AW'(6), d);
            check("R12 data across wrap", d, 32'h6000 + 32'(round * 256 + k));
         end
      end
      for (int k = 0; k < 3; k++) bus_write(AW'(6), 32'h77);
      bus_write(CFG + 6, cfg_word(32, 0, 0, 0));
      rd(ST + 0, d);  check("R2 config write empties", nib(d, 6), 32'h3);
      rd(AW'(6), d);  check("R2 emptied queue pops 0", d, 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_order();
      t_independent();
      t_empty_pop();
      t_full_ovf();
      t_watermarks();
      t_upper();
      t_unconfig();
      t_wrap();
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule